// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Sequencer

This block is the digital control core of a multi-channel converter whose inputs are all held at the same instant. A start request arrives asynchronously. The block then freezes the sample values of three main inputs and of one chosen auxiliary input. A two-bit mode code picks the channels to convert, and each of those channels takes a fixed number of clocks. An active-low busy flag covers the whole batch. Each channel's conversion is modelled as a capture after a fixed delay, so the sample values arrive as digital words on input ports.

Results go into a bank of four registers that a host reads through a chip-select, read-strobe and two-bit address port. Both strobes are active low. The whole batch of new results is published at once, on the clock edge where busy returns high. Until then the previous batch stays readable, so a host can poll or read at any time and always gets a consistent set. All sequential logic is clocked on the falling edge of `clk`. The reset is synchronous and active high.

Top module: `adc_seq_top`

## Requirements
- R1: `busy_n` stays low for exactly 40 × n clock cycles per batch. n is 2 for mode 00, 3 for modes 01 and 10, and 4 for mode 11.
- R2: `conv_start` passes through a two-stage synchronizer. A rising level that arrives between two edges pulls `busy_n` low on the third falling clock edge after it, and not earlier.
- R3: A start rise seen while `busy_n` is low is ignored. A start held high does not trigger a second batch; only a fresh low-to-high change starts one.
- R4: Mode 00 converts the second and third main inputs. Mode 01 adds the auxiliary channel. Mode 10 converts all three main inputs. Mode 11 converts all three main inputs and the auxiliary channel. Registers of channels outside the mode keep their previous value.
- R5: `aux_sel` value k (0 to 3) routes auxiliary input k to the auxiliary result register.
- R6: While `busy_n` is low, every register reads its previous value. All new results appear together on the edge where `busy_n` returns high.
- R7: The mode, the auxiliary select and all sample values are taken on the edge where `busy_n` falls. Later changes to them do not affect the batch.
- R8: A read returns the 11-bit result in `rd_data[11:1]`, and `rd_data[0]` is 0. `rd_addr` 0 selects the first main input, 1 the second, 2 the third and 3 the auxiliary channel.
- R9: `rd_drive` is 1, and `rd_data` is driven, only while `cs_n` and `rd_n` are both low. Otherwise the bus is high-impedance.
- R10: Reset returns the sequencer to idle with `busy_n` high and clears all four result registers to zero, even in the middle of a batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Asynchronous conversion request, rising edge starts a batch |
| mode_sel | input | 2 | Channel-set code |
| aux_sel | input | 2 | Auxiliary input selector |
| vin1 | input | 11 | Sample value, first main input |
| vin2 | input | 11 | Sample value, second main input |
| vin3 | input | 11 | Sample value, third main input |
| aux_in | input | 4×11 | Sample values of the four auxiliary inputs |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Read strobe, active low |
| rd_addr | input | 2 | Result register address |
| busy_n | output | 1 | Low while a batch is in progress |
| rd_drive | output | 1 | High while the data bus is driven |
| rd_data | output | 12 | Read data bus, tri-stated when not driven |

## Verification
Four properties are checked on every cycle. The length of each busy-low window must match the channel count of the mode taken at the start. Busy may fall only after a synchronized start event. The published registers must not move while busy is low. The latched mode must hold for the whole batch. Other behaviours can only be shown by the bench's scenarios, because they need the sample values and a model of what should have been captured. These are the mapping of each mode to its channels, the auxiliary routing, the insensitivity to input changes after the start, the read format and address map, the ignoring of extra starts, and the reset in the middle of a batch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAMPLE_W   = 11;
    localparam int NUM_CH     = 4;
    localparam int CONV_CLKS  = 40;
    localparam int SYNC_DEPTH = 2;

    // Encoding equals the read address of each result register
    typedef enum logic [1:0] {
        CH_VIN1 = 2'd0,
        CH_VIN2 = 2'd1,
        CH_VIN3 = 2'd2,
        CH_AUX  = 2'd3
    } chan_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-cycle commands from the sequencer to the result bank
    typedef struct packed {
        logic  capture;
        logic  wr;
        chan_e ch;
        logic  commit;
    } bank_ctl_t;

    // Number of channels converted for a mode code
    function automatic logic [2:0] chan_count(input logic [1:0] mode);
        logic [2:0] n;
        case (mode)
            2'b00:   n = 3'd2;
            2'b01:   n = 3'd3;
            2'b10:   n = 3'd3;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    // Channel converted in slot idx: first main input only when mode[1] is set,
    // the auxiliary channel always last
    function automatic chan_e chan_at(input logic [1:0] mode, input logic [1:0] idx);
        logic [1:0] base;
        base = mode[1] ? 2'd0 : 2'd1;
        return chan_e'(base + idx);
    endfunction

endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
    parameter int STAGES = adc_seq_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic evt_o
);
    logic [STAGES:0] chain_q;

    always_ff @(negedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    // One-cycle pulse on a synchronized low-to-high change
    assign evt_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = CONV_CLKS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_evt,
    input  logic [1:0] mode_i,
    output logic      busy_n,
    output bank_ctl_t ctl_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       idx_q;
    logic [1:0]       mode_q;
    logic [1:0]       last_idx;
    logic [2:0]       n_ch;
    logic             step_end;

    assign n_ch     = chan_count(mode_q);
    assign last_idx = 2'(n_ch - 3'd1);
    assign step_end = (state_q == SEQ_RUN) && (cnt_q == CNT_W'(CONV_CYCLES - 1));

    always_ff @(negedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            mode_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_evt) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        mode_q  <= mode_i;
                    end
                end
                default: begin
                    if (step_end) begin
                        cnt_q <= '0;
                        if (idx_q == last_idx) state_q <= SEQ_IDLE;
                        else                   idx_q   <= idx_q + 2'd1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        busy_n        = (state_q == SEQ_IDLE);
        ctl_o.capture = (state_q == SEQ_IDLE) && start_evt;
        ctl_o.wr      = step_end;
        ctl_o.ch      = chan_at(mode_q, idx_q);
        ctl_o.commit  = step_end && (idx_q == last_idx);
    end

    // R7 / R3: mid-batch the latched mode holds and a start cannot restart the batch
    a_r7_mode_held: assert property (@(negedge clk) disable iff (rst)
        (state_q == SEQ_RUN && !ctl_o.commit) |=> ($stable(mode_q) && !busy_n && $stable(idx_q) || cnt_q == '0));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  bank_ctl_t                ctl_i,
    input  logic [1:0]               aux_sel_i,
    input  logic [W-1:0]             vin1_i,
    input  logic [W-1:0]             vin2_i,
    input  logic [W-1:0]             vin3_i,
    input  logic [NUM_CH-1:0][W-1:0] aux_i,
    input  logic [1:0]               rd_addr_i,
    output logic [W-1:0]             rd_val_o
);
    logic [NUM_CH-1:0][W-1:0] hold_q;   // values frozen at the start edge
    logic [NUM_CH-1:0][W-1:0] stage_q;  // batch being assembled
    logic [NUM_CH-1:0][W-1:0] vis_q;    // registers the host sees

    always_ff @(negedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            stage_q <= '0;
            vis_q   <= '0;
        end else begin
            if (ctl_i.capture) begin
                hold_q[CH_VIN1] <= vin1_i;
                hold_q[CH_VIN2] <= vin2_i;
                hold_q[CH_VIN3] <= vin3_i;
                hold_q[CH_AUX]  <= aux_i[aux_sel_i];
                stage_q         <= vis_q;
            end
            if (ctl_i.wr) begin
                stage_q[ctl_i.ch] <= hold_q[ctl_i.ch];
            end
            if (ctl_i.commit) begin
                // the final channel is merged straight from the hold stage
                for (int c = 0; c < NUM_CH; c++) begin
                    vis_q[c] <= (chan_e'(c) == ctl_i.ch) ? hold_q[c] : stage_q[c];
                end
            end
        end
    end

    assign rd_val_o = vis_q[rd_addr_i];

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = SAMPLE_W,
    parameter int CONV_CYCLES = CONV_CLKS,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          conv_start,
    input  logic [1:0]                    mode_sel,
    input  logic [1:0]                    aux_sel,
    input  logic [DATA_W-1:0]             vin1,
    input  logic [DATA_W-1:0]             vin2,
    input  logic [DATA_W-1:0]             vin3,
    input  logic [NUM_CH-1:0][DATA_W-1:0] aux_in,
    input  logic                          cs_n,
    input  logic                          rd_n,
    input  logic [1:0]                    rd_addr,
    output logic                          busy_n,
    output logic                          rd_drive,
    output logic [DATA_W:0]               rd_data
);
    localparam int LEN_W = $clog2(CONV_CYCLES * NUM_CH + 1) + 1;

    logic              start_evt;
    bank_ctl_t         ctl;
    logic [DATA_W-1:0] rd_val;

    adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (conv_start),
        .evt_o   (start_evt)
    );

    adc_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_evt (start_evt),
        .mode_i    (mode_sel),
        .busy_n    (busy_n),
        .ctl_o     (ctl)
    );

    adc_result_bank #(.W(DATA_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .aux_sel_i (aux_sel),
        .vin1_i    (vin1),
        .vin2_i    (vin2),
        .vin3_i    (vin3),
        .aux_i     (aux_in),
        .rd_addr_i (rd_addr),
        .rd_val_o  (rd_val)
    );

    assign rd_drive = !cs_n && !rd_n;
    assign rd_data  = rd_drive ? {rd_val, 1'b0} : 'z;

    // Independent measure of the busy-low window
    logic [LEN_W-1:0] low_len_q;
    logic [2:0]       n_chk_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            low_len_q <= '0;
            n_chk_q   <= '0;
        end else begin
            low_len_q <= busy_n ? '0 : low_len_q + LEN_W'(1);
            if (busy_n && start_evt) n_chk_q <= chan_count(mode_sel);
        end
    end

    a_r1_busy_window: assert property (@(negedge clk) disable iff (rst)
        $rose(busy_n) |-> (low_len_q == LEN_W'(CONV_CYCLES * int'(n_chk_q))));

    a_r2_fall_after_start: assert property (@(negedge clk) disable iff (rst)
        $fell(busy_n) |-> $past(start_evt));

    a_r6_results_frozen: assert property (@(negedge clk) disable iff (rst)
        !busy_n |-> $stable(u_bank.vis_q));

endmodule

// File: tb/adc_seq_top_bench.sv
`timescale 1ns/1ps
module adc_seq_top_bench;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv_start = 1'b0;
    logic [1:0]        mode_sel = '0;
    logic [1:0]        aux_sel = '0;
    logic [10:0]       vin1 = '0, vin2 = '0, vin3 = '0;
    logic [3:0][10:0]  aux_in = '0;
    logic              cs_n = 1'b1, rd_n = 1'b1;
    logic [1:0]        rd_addr = '0;
    logic              busy_n;
    logic              rd_drive;
    logic [11:0]       rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [10:0] expv [4];

    always #2.5 clk = ~clk;

    adc_seq_top u_adc_seq_top (
        .clk(clk), .rst(rst), .conv_start(conv_start), .mode_sel(mode_sel),
        .aux_sel(aux_sel), .vin1(vin1), .vin2(vin2), .vin3(vin3), .aux_in(aux_in),
        .cs_n(cs_n), .rd_n(rd_n), .rd_addr(rd_addr), .busy_n(busy_n),
        .rd_drive(rd_drive), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    function automatic int n_of(input logic [1:0] m);
        return 2 + int'(m[0]) + int'(m[1]);
    endfunction

    task automatic read_reg(input logic [1:0] a, input string tag);
        @(posedge clk); #1;
        rd_addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk);
        chk({tag, " R9 drive"}, {31'd0, rd_drive}, 32'd1);
        chk({tag, " R8 word"}, {20'd0, rd_data}, {20'd0, expv[a], 1'b0});
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 4; a++) read_reg(2'(a), tag);
        @(posedge clk); #1; cs_n = 1'b0; rd_n = 1'b1;
        @(posedge clk); chk("R9 rd high", {31'd0, rd_drive}, 32'd0);
        #1; cs_n = 1'b1; rd_n = 1'b0;
        @(posedge clk); chk("R9 cs high", {31'd0, rd_drive}, 32'd0);
        #1; rd_n = 1'b1;
    endtask

    // One batch; watch = register read during the batch
    task automatic run_conv(input logic [1:0] m, input logic [1:0] ax, input logic [1:0] watch,
                            input bit mid_start, input bit hold_high);
        logic [10:0] nexp [4];
        int n;
        @(posedge clk); #1;
        mode_sel = m; aux_sel = ax;
        vin1 = 11'($urandom); vin2 = 11'($urandom); vin3 = 11'($urandom);
        for (int k = 0; k < 4; k++) aux_in[k] = 11'($urandom);
        n = n_of(m);
        for (int c = 0; c < 4; c++) nexp[c] = expv[c];
        if (m[1]) nexp[0] = vin1;      // R4
        nexp[1] = vin2;
        nexp[2] = vin3;
        if (m[0]) nexp[3] = aux_in[ax]; // R5
        repeat (3) @(posedge clk);
        @(posedge clk); #1;            // P0
        conv_start = 1'b1; rd_addr = watch; cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk);                // P1
        @(posedge clk);                // P2
        chk("R2 busy before third edge", {31'd0, busy_n}, 32'd1);
        @(posedge clk);                // P3
        chk("R2 busy after third edge", {31'd0, busy_n}, 32'd0);
        #1;                            // R7: disturb inputs after capture
        mode_sel = ~m; aux_sel = ~ax;
        vin1 = ~vin1; vin2 = ~vin2; vin3 = ~vin3;
        for (int k = 0; k < 4; k++) aux_in[k] = ~aux_in[k];
        for (int k = 4; k <= 2 + 40 * n; k++) begin
            @(posedge clk);
            if (k == 2 + 40 * n) begin
                chk("R1 busy in last cycle", {31'd0, busy_n}, 32'd0);
                chk("R6 old data in last cycle", {20'd0, rd_data}, {20'd0, expv[watch], 1'b0});
            end
            if (k == 6 && !hold_high) begin #1; conv_start = 1'b0; end
            if (mid_start && k == 20) begin #1; conv_start = 1'b1; end  // R3
            if (mid_start && k == 25) begin #1; conv_start = 1'b0; end
        end
        @(posedge clk);                // P(3+40n)
        chk("R1 busy released", {31'd0, busy_n}, 32'd1);
        chk("R6 new data at release", {20'd0, rd_data}, {20'd0, nexp[watch], 1'b0});
        for (int c = 0; c < 4; c++) expv[c] = nexp[c];
        repeat (6) @(posedge clk);
        chk("R3 no retrigger", {31'd0, busy_n}, 32'd1);
        #1; conv_start = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
        read_all("R4 R5 R7 readback");
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < 4; c++) expv[c] = '0;
        repeat (4) @(posedge clk);
        #1; rst = 1'b0;
        @(posedge clk);
        chk("R10 busy after reset", {31'd0, busy_n}, 32'd1);
        chk("R9 idle bus", {31'd0, rd_drive}, 32'd0);
        read_all("R10 reset values");

        // directed: every mode, every aux select
        run_conv(2'b00, 2'd0, 2'd1, 1'b0, 1'b0);
        run_conv(2'b01, 2'd1, 2'd3, 1'b1, 1'b0);
        run_conv(2'b10, 2'd2, 2'd0, 1'b0, 1'b1);
        run_conv(2'b11, 2'd3, 2'd2, 1'b1, 1'b1);
        // random mix
        for (int i = 0; i < 8; i++)
            run_conv(2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));

        // R10: reset in the middle of a batch
        @(posedge clk); #1; mode_sel = 2'b11; conv_start = 1'b1;
        repeat (30) @(posedge clk);
        chk("R10 busy before mid reset", {31'd0, busy_n}, 32'd0);
        #1; rst = 1'b1; conv_start = 1'b0;
        repeat (2) @(posedge clk);
        chk("R10 busy during reset", {31'd0, busy_n}, 32'd1);
        #1; rst = 1'b0;
        for (int c = 0; c < 4; c++) expv[c] = '0;
        repeat (5) @(posedge clk);
        chk("R10 idle after mid reset", {31'd0, busy_n}, 32'd1);
        read_all("R10 cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule